// File: doc/BRIEF.md
# Board Interrupt Aggregator

This block gathers up to sixteen interrupt requests from devices on a board and presents them to a host processor as one active-low level interrupt line. Each request input is brought into the block's clock domain and recorded as a pending bit. The pending bit stays set until the host clears it, even if the request has already gone away. A host reaches the block over a small 16-bit word bus with separate read and write strobes. Read data appears one cycle after the read strobe.

The host sees a read-only pending register and a mask register, where a 1 disables a source. It also has a clear register: a 1 written there forces the matching pending bit to 0 and keeps it at 0 until the host writes the bit back to 0. Three fixed signature words let software detect that the board is fitted, and a revision word identifies the design. The interrupt line is low whenever at least one pending bit is not masked.

A parameter chooses how a pending bit is set. In edge mode it is set on a rising edge of its synchronised request. In level mode it is set on every cycle that the request is high.

Top module: `brd_irq_hub`

## Requirements
- R1: After reset the pending register reads 0x0000, the mask reads 0xFFFF, the clear register reads 0x0000 and `irq_n_o` is 1.
- R2: Word addresses 3, 4 and 5 read 0xAAAA, 0x5555 and 0xCAFE. Address 6 reads the `REV_CODE` parameter.
- R3: In edge mode, a rising edge on `src_i[k]` sets pending bit k (address 0) at the third rising clock edge after the input goes high. A request that stays high sets the bit only once.
- R4: A pending bit stays set after its request falls, until it is cleared through the clear register.
- R5: `irq_n_o` is 0 exactly when some pending bit has its mask bit (address 1) at 0. A mask bit of 1 disables its source.
- R6: Writing 1 to bit k of the clear register (address 2) clears pending bit k at that write. The bit is then held at 0, and new events are dropped, until bit k of the clear register is written back to 0.
- R7: A set event on a bit whose clear bit is 0 is never lost, even in the cycle of another clear write.
- R8: Writes to addresses 0, 3, 4, 5, 6 and 7 change no register, pending bit or output.
- R9: Read data is presented on `bus_rdata_o` after the clock edge that samples `bus_rd_i`, and holds until the next read. Address 7 reads 0x0000. Pending and clear bits above `NUM_SRC` read 0, and mask bits above it read 1.
- R10: In level mode, a pending bit whose request is high is set again on the first cycle after its clear bit is released.
- R11: The start-up sequence works: mask 0, clear 0xFFFF, clear 0, mask 0x001F. After it, sources 0 to 4 latch without driving the interrupt, and sources 5 and up drive it.
- R12: A mask write alone changes `irq_n_o` at the clock edge of that write, without changing the pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Asynchronous interrupt requests |
| bus_addr_i | input | 3 | Word address |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Registered read data |
| irq_n_o | output | 1 | Combined interrupt, active low |

## Verification
The bench builds two copies of the block on one shared bus. The first uses sixteen sources in edge mode, which covers the full register width, the top source bit and the edge-only set behaviour. The second uses five sources in level mode, which brings in the padding of the unused upper bits on reads and re-setting while a request is still high. The two copies also use different revision codes, so the revision read-back cannot pass by coincidence.

// File: rtl/brd_irq_pkg.sv
package brd_irq_pkg;
    localparam int REG_W  = 16;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_PEND  = 3'd0,
        A_MASK  = 3'd1,
        A_CLEAR = 3'd2,
        A_SIG0  = 3'd3,
        A_SIG1  = 3'd4,
        A_SIG2  = 3'd5,
        A_REV   = 3'd6,
        A_SPARE = 3'd7
    } reg_addr_e;

    localparam logic [REG_W-1:0] SIG0_WORD = 16'hAAAA;
    localparam logic [REG_W-1:0] SIG1_WORD = 16'h5555;
    localparam logic [REG_W-1:0] SIG2_WORD = 16'hCAFE;
endpackage

// File: rtl/brd_irq_sync.sv
module brd_irq_sync #(
    parameter int NUM_SRC   = 16,
    parameter bit LEVEL_SET = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    output logic [NUM_SRC-1:0] set_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] s1;
        logic [NUM_SRC-1:0] s2;
        logic [NUM_SRC-1:0] prev;
    } sync_t;

    sync_t cur_q, nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.s1   = src_i;
        nxt_d.s2   = cur_q.s1;
        nxt_d.prev = cur_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    generate
        if (LEVEL_SET) begin : g_level
            assign set_o = cur_q.s2;
        end else begin : g_edge
            assign set_o = cur_q.s2 & ~cur_q.prev;
            // A held request yields a single set pulse per rising edge.
            assert_one_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (set_o != '0) |=> ((set_o & $past(set_o)) == '0));
        end
    endgenerate
endmodule

// File: rtl/brd_irq_pend.sv
module brd_irq_pend #(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] clr_i,
    input  logic [NUM_SRC-1:0] mask_nxt_i,
    output logic [NUM_SRC-1:0] pend_o,
    output logic               irq_n_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
        logic               irq_n;
    } pend_t;

    pend_t cur_q, nxt_d;

    always_comb begin
        nxt_d       = cur_q;
        // Clear bit outranks a set; with clear at 0 a set always lands.
        nxt_d.pend  = (cur_q.pend | set_i) & ~clr_i;
        nxt_d.irq_n = ~|(nxt_d.pend & ~mask_nxt_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.pend  <= '0;
            cur_q.irq_n <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign pend_o  = cur_q.pend;
    assign irq_n_o = cur_q.irq_n;

    assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) |=> ((pend_o & $past(clr_i)) == '0));

    assert_set_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i & ~clr_i) != '0) |=>
            ((pend_o & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i)));

    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(pend_o) & ~$past(clr_i) & ~pend_o) == '0));
endmodule

// File: rtl/brd_irq_regs.sv
module brd_irq_regs
    import brd_irq_pkg::*;
#(
    parameter int               NUM_SRC  = 16,
    parameter logic [REG_W-1:0] REV_CODE = 16'h0102
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               rd_i,
    input  logic               wr_i,
    input  logic [REG_W-1:0]   wdata_i,
    input  logic [NUM_SRC-1:0] pend_i,
    output logic [NUM_SRC-1:0] mask_o,
    output logic [NUM_SRC-1:0] mask_nxt_o,
    output logic [NUM_SRC-1:0] clr_eff_o,
    output logic [REG_W-1:0]   rdata_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] mask;
        logic [NUM_SRC-1:0] clr;
        logic [REG_W-1:0]   rdata;
    } regs_t;

    regs_t cur_q, nxt_d;
    logic [REG_W-1:0] pend_ext, mask_ext, clr_ext, rd_mux;
    logic wr_mask, wr_clr;

    always_comb begin
        pend_ext = '0;
        pend_ext[NUM_SRC-1:0] = pend_i;
        mask_ext = '1;
        mask_ext[NUM_SRC-1:0] = cur_q.mask;
        clr_ext  = '0;
        clr_ext[NUM_SRC-1:0] = cur_q.clr;
        case (reg_addr_e'(addr_i))
            A_PEND:  rd_mux = pend_ext;
            A_MASK:  rd_mux = mask_ext;
            A_CLEAR: rd_mux = clr_ext;
            A_SIG0:  rd_mux = SIG0_WORD;
            A_SIG1:  rd_mux = SIG1_WORD;
            A_SIG2:  rd_mux = SIG2_WORD;
            A_REV:   rd_mux = REV_CODE;
            default: rd_mux = '0;
        endcase
    end

    always_comb begin
        wr_mask = wr_i && (reg_addr_e'(addr_i) == A_MASK);
        wr_clr  = wr_i && (reg_addr_e'(addr_i) == A_CLEAR);
        nxt_d   = cur_q;
        if (wr_mask) nxt_d.mask  = wdata_i[NUM_SRC-1:0];
        if (wr_clr)  nxt_d.clr   = wdata_i[NUM_SRC-1:0];
        if (rd_i)    nxt_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.mask  <= '1;
            cur_q.clr   <= '0;
            cur_q.rdata <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign mask_o     = cur_q.mask;
    assign mask_nxt_o = nxt_d.mask;
    assign clr_eff_o  = nxt_d.clr;
    assign rdata_o    = cur_q.rdata;

    assert_sig_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && addr_i == A_SIG2) |=> (rdata_o == SIG2_WORD));

    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rdata_o));

    assert_ro_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i != A_MASK && addr_i != A_CLEAR) |=>
            ($stable(mask_o) && $stable(cur_q.clr)));
endmodule

// File: rtl/brd_irq_hub.sv
module brd_irq_hub
    import brd_irq_pkg::*;
#(
    parameter int               NUM_SRC   = 16,
    parameter bit               LEVEL_SET = 1'b0,
    parameter logic [REG_W-1:0] REV_CODE  = 16'h0102
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic               bus_rd_i,
    input  logic               bus_wr_i,
    input  logic [REG_W-1:0]   bus_wdata_i,
    output logic [REG_W-1:0]   bus_rdata_o,
    output logic               irq_n_o
);
    logic [NUM_SRC-1:0] set_w, pend_w, mask_w, mask_nxt_w, clr_w;

    brd_irq_sync #(.NUM_SRC(NUM_SRC), .LEVEL_SET(LEVEL_SET)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .src_i (src_i),
        .set_o (set_w)
    );

    brd_irq_regs #(.NUM_SRC(NUM_SRC), .REV_CODE(REV_CODE)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (bus_addr_i),
        .rd_i       (bus_rd_i),
        .wr_i       (bus_wr_i),
        .wdata_i    (bus_wdata_i),
        .pend_i     (pend_w),
        .mask_o     (mask_w),
        .mask_nxt_o (mask_nxt_w),
        .clr_eff_o  (clr_w),
        .rdata_o    (bus_rdata_o)
    );

    brd_irq_pend #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (set_w),
        .clr_i      (clr_w),
        .mask_nxt_i (mask_nxt_w),
        .pend_o     (pend_w),
        .irq_n_o    (irq_n_o)
    );

    assert_irq_combine_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n_o == ~|(pend_w & ~mask_w));

    assert_mask_only_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == A_MASK && clr_w == '0 && set_w == '0) |=>
            $stable(pend_w));
endmodule

// File: tb/brd_irq_hub_tb_top.sv
module brd_irq_hub_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_m = '0;
    logic [4:0]  src_l = '0;
    logic [2:0]  addr = '0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata_m, rdata_l;
    logic        irq_m, irq_l;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    brd_irq_hub #(.NUM_SRC(16), .LEVEL_SET(1'b0), .REV_CODE(16'h0102)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src_m), .bus_addr_i(addr), .bus_rd_i(rd),
        .bus_wr_i(wr), .bus_wdata_i(wdata), .bus_rdata_o(rdata_m), .irq_n_o(irq_m));

    brd_irq_hub #(.NUM_SRC(5), .LEVEL_SET(1'b1), .REV_CODE(16'h0205)) dut_lvl (
        .clk(clk), .rst_n(rst_n), .src_i(src_l), .bus_addr_i(addr), .bus_rd_i(rd),
        .bus_wr_i(wr), .bus_wdata_i(wdata), .bus_rdata_o(rdata_l), .irq_n_o(irq_l));

    // {source pulse, mask, expected pending, expected irq_n}
    localparam logic [48:0] VEC [6] = '{
        {16'h0001, 16'h0000, 16'h0001, 1'b0},
        {16'h0003, 16'h0003, 16'h0003, 1'b1},
        {16'h8000, 16'h7FFF, 16'h8000, 1'b0},
        {16'h0000, 16'h0000, 16'h0000, 1'b1},
        {16'hA5A5, 16'hA5A4, 16'hA5A5, 1'b0},
        {16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b1}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [15:0] dm, output logic [15:0] dl);
        @(negedge clk); addr = a; rd = 1'b1;
        @(negedge clk); rd = 1'b0; dm = rdata_m; dl = rdata_l;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_m(input logic [15:0] p);
        @(negedge clk); src_m = p;
        wait_n(4);
        src_m = '0;
        wait_n(3);
    endtask

    task automatic clear_all();
        bus_wr(3'd2, 16'hFFFF);
        bus_wr(3'd2, 16'h0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] a, b;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);

        // R1 reset state
        chk("R1 irq_n", {15'd0, irq_m}, 16'h1);
        bus_rd(3'd0, a, b); chk("R1 pend", a, 16'h0000);
        bus_rd(3'd1, a, b); chk("R1 mask", a, 16'hFFFF); chk("R1 mask lvl", b, 16'hFFFF);
        bus_rd(3'd2, a, b); chk("R1 clear", a, 16'h0000);

        // R2 identification words
        bus_rd(3'd3, a, b); chk("R2 sig0", a, 16'hAAAA);
        bus_rd(3'd4, a, b); chk("R2 sig1", a, 16'h5555);
        bus_rd(3'd5, a, b); chk("R2 sig2", b, 16'hCAFE);
        bus_rd(3'd6, a, b); chk("R2 rev", a, 16'h0102); chk("R2 rev lvl", b, 16'h0205);
        // R9 spare address
        bus_rd(3'd7, a, b); chk("R9 spare", a, 16'h0000);

        // R3 R4 R5 vector walk
        foreach (VEC[i]) begin
            clear_all();
            bus_wr(3'd1, VEC[i][32:17]);
            pulse_m(VEC[i][48:33]);
            bus_rd(3'd0, a, b);
            chk($sformatf("R4 pend vec%0d", i), a, VEC[i][16:1]);
            chk($sformatf("R5 irq vec%0d", i), {15'd0, irq_m}, {15'd0, VEC[i][0]});
        end

        // R8 writes to read-only addresses leave state unchanged (pend=FFFF, mask=FFFF)
        bus_wr(3'd0, 16'h0000);
        bus_wr(3'd3, 16'h1234);
        bus_wr(3'd6, 16'h0000);
        bus_wr(3'd7, 16'h0000);
        bus_rd(3'd0, a, b); chk("R8 pend", a, 16'hFFFF);
        bus_rd(3'd3, a, b); chk("R8 sig0", a, 16'hAAAA);
        bus_rd(3'd6, a, b); chk("R8 rev", a, 16'h0102);
        bus_rd(3'd1, a, b); chk("R8 mask", a, 16'hFFFF);
        chk("R8 irq_n", {15'd0, irq_m}, 16'h1);

        // R11 start-up sequence
        bus_wr(3'd1, 16'h0000);
        bus_wr(3'd2, 16'hFFFF);
        bus_wr(3'd2, 16'h0000);
        bus_wr(3'd1, 16'h001F);
        bus_rd(3'd0, a, b); chk("R11 pend clean", a, 16'h0000);
        chk("R11 irq idle", {15'd0, irq_m}, 16'h1);
        pulse_m(16'h0004);
        chk("R11 masked src", {15'd0, irq_m}, 16'h1);
        pulse_m(16'h0040);
        chk("R11 open src", {15'd0, irq_m}, 16'h0);
        bus_rd(3'd0, a, b); chk("R11 pend", a, 16'h0044);

        // R12 mask alone toggles irq_n
        @(negedge clk); addr = 3'd1; wdata = 16'hFFFF; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
        chk("R12 masked", {15'd0, irq_m}, 16'h1);
        bus_wr(3'd1, 16'h0000);
        chk("R12 unmasked", {15'd0, irq_m}, 16'h0);
        bus_rd(3'd0, a, b); chk("R12 pend kept", a, 16'h0044);

        // R3 held source sets only once
        clear_all();
        @(negedge clk); src_m = 16'h0010;
        wait_n(5);
        clear_all();
        wait_n(3);
        bus_rd(3'd0, a, b); chk("R3 held no reset", a, 16'h0000);
        src_m = '0;
        wait_n(3);

        // R6 clear held blocks events, release re-arms; R7 other bit still sets
        bus_wr(3'd2, 16'h0020);
        bus_rd(3'd2, a, b); chk("R6 clear rd", a, 16'h0020);
        pulse_m(16'h0120);
        bus_rd(3'd0, a, b); chk("R7 pend", a, 16'h0100);
        bus_wr(3'd2, 16'h0000);
        bus_rd(3'd0, a, b); chk("R6 release", a, 16'h0100);
        pulse_m(16'h0020);
        bus_rd(3'd0, a, b); chk("R6 rearm", a, 16'h0120);

        // R10 level mode on the second instance
        clear_all();
        @(negedge clk); src_l = 5'b00010;
        wait_n(4);
        bus_rd(3'd0, a, b); chk("R10 lvl set", b, 16'h0002);
        chk("R10 lvl irq", {15'd0, irq_l}, 16'h0);
        bus_wr(3'd2, 16'h0002);
        bus_rd(3'd0, a, b); chk("R10 lvl held", b, 16'h0000);
        bus_rd(3'd2, a, b); chk("R9 lvl clear pad", b, 16'h0002);
        bus_wr(3'd2, 16'h0000);
        bus_rd(3'd0, a, b); chk("R10 lvl reset", b, 16'h0002);
        src_l = '0;
        wait_n(3);
        clear_all();
        bus_rd(3'd0, a, b); chk("R10 lvl gone", b, 16'h0000);
        chk("R10 lvl irq off", {15'd0, irq_l}, 16'h1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule